// File: doc/BRIEF.md
# Day-Time Clock with Alarm Interrupt

This block is a memory-mapped time-of-day clock for a chip's always-on domain. It holds a day count, an hour and minute pair, and a seconds count. All of them advance by one second on each pulse of an external 1 Hz tick, and only while the run bit in the control register is set. A second set of registers holds an alarm time. The alarm is compared over all four fields on every counting tick.

Two event bits record activity: one for each counted second and one for an alarm match. Each bit is write-one-to-clear. An enable mask gates the events onto a single level interrupt. Software reads and writes the clock over a simple 16-bit bus. The bus has a 4-bit word index, synchronous writes and a combinational read path. Conversion to calendar dates is left to software.

Top module: `daytime_rtc`

## Requirements
- R1: After reset, every register reads zero, counting is stopped and `irq` is low.
- R2: The word index selects the register:
  - 0: hour/minute, with the hour in bits [12:8] and the minute in bits [5:0].
  - 1: seconds, in bits [5:0].
  - 2: alarm hour/minute, with the same layout as index 0.
  - 3: alarm seconds.
  - 4: control, with the run bit at bit 7.
  - 5: event status.
  - 6: event enable.
  - 7: stopwatch. It reads zero and ignores writes.
  - 8: day count, in the low DAY_W bits.
  - 9: alarm day.
  - Every other index, and every unimplemented bit, reads zero.
- R3: While the run bit is clear, a tick changes no time field and sets no event bit.
- R4: A counting tick adds one second. A seconds value of 59 or more becomes 0 and carries into the minute.
- R5: A minute of 59 or more wraps to 0 and carries into the hour. An hour of 23 or more wraps to 0 and carries into the day.
- R6: The day count wraps from 2^DAY_W-1 to 0.
- R7: Every tick taken while running sets status bit 4 (the seconds event).
- R8: Status bit 2 (the alarm event) is set when the time produced by a counting tick equals the alarm day, hour, minute and second.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event raised in the same cycle as a clearing write wins. Only bits 2 and 4 can ever be 1.
- R10: `irq` is high exactly when some status bit and its enable bit (bits 2 and 4 only) are both 1. Status bits still record events while they are disabled.
- R11: A write to the seconds, hour/minute or day register takes priority over a tick in the same cycle. The written value lands, and no time field advances in that cycle. The seconds event is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle pulse, once per second |
| busWrite | input | 1 | Write strobe for the addressed register |
| busAddr | input | 4 | Register word index |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt: status AND enable, ORed |

## Verification
A wrong carry or wrap shows up at the next read of the seconds, hour/minute or day register after the faulty tick. The bench reads all registers back after its directed steps and regularly during the random run, so such a fault is caught within a few operations. A fault in the alarm compare or in the status update appears on `irq` one clock after the tick. A fault in the clear path appears on `irq` one clock after the status write, provided the matching enable bit is set. Priority faults between writes and ticks show up on the very read that follows the collision.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;

  localparam logic [ADDR_W-1:0] IDX_HM     = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_SEC    = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_AHM    = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_ASEC   = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_CTRL   = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_STAT   = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_IEN    = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_SWATCH = 4'd7;
  localparam logic [ADDR_W-1:0] IDX_DAY    = 4'd8;
  localparam logic [ADDR_W-1:0] IDX_ADAY   = 4'd9;

  localparam int CTRL_RUN  = 7;
  localparam int STAT_ALM  = 2;
  localparam int STAT_SEC  = 4;
  localparam logic [DATA_W-1:0] STAT_MASK = (DATA_W'(1) << STAT_ALM) | (DATA_W'(1) << STAT_SEC);

  typedef struct packed {
    logic wrHm;
    logic wrSec;
    logic wrAhm;
    logic wrAsec;
    logic wrStat;
    logic wrIen;
    logic wrDay;
    logic wrAday;
    logic tickEvt;
    logic tickGo;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  input  logic         step,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt,
  output logic         carryOut
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic atLast;

  always_comb begin
    atLast   = (q >= LAST_V);
    carryOut = step & atLast;
    if (!step)       nxt = q;
    else if (atLast) nxt = '0;
    else             nxt = q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)   q <= '0;
    else if (ld) q <= ldVal;
    else         q <= nxt;
  end

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && atLast && !ld) |=> (q == '0));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!step && !ld) |=> $stable(q));
  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ld |=> (q == $past(ldVal)));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output rtcStrobe_t        strb,
  output logic              runQ
);
  logic timeWr;

  always_comb begin
    strb.wrHm    = busWrite && (busAddr == IDX_HM);
    strb.wrSec   = busWrite && (busAddr == IDX_SEC);
    strb.wrAhm   = busWrite && (busAddr == IDX_AHM);
    strb.wrAsec  = busWrite && (busAddr == IDX_ASEC);
    strb.wrStat  = busWrite && (busAddr == IDX_STAT);
    strb.wrIen   = busWrite && (busAddr == IDX_IEN);
    strb.wrDay   = busWrite && (busAddr == IDX_DAY);
    strb.wrAday  = busWrite && (busAddr == IDX_ADAY);
    timeWr       = strb.wrHm | strb.wrSec | strb.wrDay;
    strb.tickEvt = tick1Hz & runQ;
    strb.tickGo  = tick1Hz & runQ & ~timeWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      runQ <= 1'b0;
    else if (busWrite && (busAddr == IDX_CTRL))
      runQ <= busWdata[CTRL_RUN];
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strb,
  input  logic              runQ,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  localparam int DAY_LAST = (1 << DAY_W) - 1;
  localparam int NF = 4;

  localparam int FW [NF] = '{SEC_W, MIN_W, HOUR_W, DAY_W};
  localparam int FL [NF] = '{SEC_LAST, MIN_LAST, HOUR_LAST, DAY_LAST};

  logic [SEC_W-1:0]  secQ, secNx, almSec;
  logic [MIN_W-1:0]  minQ, minNx, almMin;
  logic [HOUR_W-1:0] hourQ, hourNx, almHour;
  logic [DAY_W-1:0]  dayQ, dayNx, almDay;
  logic [DATA_W-1:0] statQ, ienQ, statNx, clrMask, setMask;
  logic [NF:0]       carry;
  logic              alarmHit;

  assign carry[0] = strb.tickGo;

  // One counting field per stage, chained through the carries.
  for (genvar i = 0; i < NF; i++) begin : g_field
    logic [FW[i]-1:0] q, nxt;
    logic [FW[i]-1:0] ldVal;
    logic             ld;

    if (i == 0) begin : g_sec
      assign ld    = strb.wrSec;
      assign ldVal = busWdata[SEC_W-1:0];
    end else if (i == 1) begin : g_min
      assign ld    = strb.wrHm;
      assign ldVal = busWdata[MIN_W-1:0];
    end else if (i == 2) begin : g_hour
      assign ld    = strb.wrHm;
      assign ldVal = busWdata[8 +: HOUR_W];
    end else begin : g_day
      assign ld    = strb.wrDay;
      assign ldVal = busWdata[DAY_W-1:0];
    end

    rtc_field #(.W(FW[i]), .LAST(FL[i])) u_field (
      .clk(clk), .rstN(rstN), .ld(ld), .ldVal(ldVal), .step(carry[i]),
      .q(q), .nxt(nxt), .carryOut(carry[i+1])
    );
  end

  assign secQ   = g_field[0].q;
  assign secNx  = g_field[0].nxt;
  assign minQ   = g_field[1].q;
  assign minNx  = g_field[1].nxt;
  assign hourQ  = g_field[2].q;
  assign hourNx = g_field[2].nxt;
  assign dayQ   = g_field[3].q;
  assign dayNx  = g_field[3].nxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almSec  <= '0;
      almMin  <= '0;
      almHour <= '0;
      almDay  <= '0;
      ienQ    <= '0;
      statQ   <= '0;
    end else begin
      if (strb.wrAsec) almSec <= busWdata[SEC_W-1:0];
      if (strb.wrAhm) begin
        almMin  <= busWdata[MIN_W-1:0];
        almHour <= busWdata[8 +: HOUR_W];
      end
      if (strb.wrAday) almDay <= busWdata[DAY_W-1:0];
      if (strb.wrIen)  ienQ   <= busWdata & STAT_MASK;
      statQ <= statNx;
    end
  end

  always_comb begin
    alarmHit = strb.tickGo && (secNx == almSec) && (minNx == almMin) &&
               (hourNx == almHour) && (dayNx == almDay);
    clrMask = strb.wrStat ? busWdata : '0;
    setMask = '0;
    setMask[STAT_SEC] = strb.tickEvt;
    setMask[STAT_ALM] = alarmHit;
    statNx = ((statQ & ~clrMask) | setMask) & STAT_MASK;
  end

  assign irq = |(statQ & ienQ);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      IDX_HM:   busRdata = {3'b0, hourQ, 2'b0, minQ};
      IDX_SEC:  busRdata[SEC_W-1:0] = secQ;
      IDX_AHM:  busRdata = {3'b0, almHour, 2'b0, almMin};
      IDX_ASEC: busRdata[SEC_W-1:0] = almSec;
      IDX_CTRL: busRdata[CTRL_RUN] = runQ;
      IDX_STAT: busRdata = statQ;
      IDX_IEN:  busRdata = ienQ;
      IDX_DAY:  busRdata[DAY_W-1:0] = dayQ;
      IDX_ADAY: busRdata[DAY_W-1:0] = almDay;
      default:  busRdata = '0;
    endcase
  end

  // R8
  alarm_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> statQ[STAT_ALM]);
  // R7
  second_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tickEvt |=> statQ[STAT_SEC]);
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && busWdata[STAT_SEC] && !strb.tickEvt) |=> !statQ[STAT_SEC]);
  // R9
  stat_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statQ & ~STAT_MASK) == '0);
  // R3
  idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !strb.wrStat && !statQ[STAT_SEC]) |=> !statQ[STAT_SEC]);
  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrHm, strb.wrSec, strb.wrAhm, strb.wrAsec,
              strb.wrStat, strb.wrIen, strb.wrDay, strb.wrAday}));
endmodule

// File: rtl/daytime_rtc.sv
module daytime_rtc
  import rtc_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  rtcStrobe_t strb;
  logic       runQ;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .strb(strb), .runQ(runQ)
  );

  rtc_datapath #(.DAY_W(DAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .runQ(runQ), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );
endmodule

// File: tb/daytime_rtc_bench.sv
`timescale 1ns/1ps
module daytime_rtc_bench;
  localparam int DAY_W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick1Hz = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [DAY_W-1:0] mDay, aDay;
  logic [4:0] mHour, aHour;
  logic [5:0] mMin, aMin, mSec, aSec;
  logic [15:0] mStat, mIen;
  logic mRun;

  daytime_rtc #(.DAY_W(DAY_W)) u_daytime_rtc (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(int idx);
    case (idx)
      0: return {3'b0, mHour, 2'b0, mMin};
      1: return {10'b0, mSec};
      2: return {3'b0, aHour, 2'b0, aMin};
      3: return {10'b0, aSec};
      4: return {8'b0, mRun, 7'b0};
      5: return mStat;
      6: return mIen;
      8: return 16'(mDay);
      9: return 16'(aDay);
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [DAY_W+16:0] advance(logic [DAY_W-1:0] d, logic [4:0] h,
                                                 logic [5:0] m, logic [5:0] s);
    if (s >= 59) begin
      s = 0;
      if (m >= 59) begin
        m = 0;
        if (h >= 23) begin h = 0; d = d + 1'b1; end
        else h = h + 1'b1;
      end else m = m + 1'b1;
    end else s = s + 1'b1;
    return {d, h, m, s};
  endfunction

  task automatic modelCycle(bit wr, int idx, logic [15:0] data, bit tk);
    bit timeWr = wr && (idx == 0 || idx == 1 || idx == 8);
    bit evt = tk && mRun;
    bit go = evt && !timeWr;
    logic [DAY_W+16:0] nx = go ? advance(mDay, mHour, mMin, mSec) : {mDay, mHour, mMin, mSec};
    bit hit = go && (nx == {aDay, aHour, aMin, aSec});
    logic [15:0] ns = mStat & ~((wr && idx == 5) ? data : 16'h0);
    if (evt) ns[4] = 1'b1;
    if (hit) ns[2] = 1'b1;
    ns = ns & 16'h0014;
    {mDay, mHour, mMin, mSec} = nx;
    mStat = ns;
    if (wr) begin
      case (idx)
        0: begin mHour = data[12:8]; mMin = data[5:0]; end
        1: mSec = data[5:0];
        2: begin aHour = data[12:8]; aMin = data[5:0]; end
        3: aSec = data[5:0];
        4: mRun = data[7];
        6: mIen = data & 16'h0014;
        8: mDay = data[DAY_W-1:0];
        9: aDay = data[DAY_W-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic doOp(bit wr, int idx, logic [15:0] data, bit tk);
    @(negedge clk);
    busWrite = wr; busAddr = 4'(idx); busWdata = data; tick1Hz = tk;
    @(posedge clk);
    modelCycle(wr, idx, data, tk);
    #1;
    busWrite = 1'b0; tick1Hz = 1'b0;
  endtask

  task automatic rdChk(string tag, int idx);
    @(negedge clk);
    busAddr = 4'(idx);
    #1;
    chk(tag, busRdata, expRead(idx));
  endtask

  task automatic irqChk(string tag);
    @(negedge clk);
    #1;
    chk(tag, {15'b0, irq}, {15'b0, |(mStat & mIen)});
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < 16; i++) rdChk(tag, i);
    irqChk({tag, " irq"});
  endtask

  function automatic logic [15:0] hm(int h, int m);
    return 16'((h << 8) | m);
  endfunction

  initial begin
    mDay = '0; aDay = '0; mHour = '0; aHour = '0; mMin = '0; aMin = '0;
    mSec = '0; aSec = '0; mStat = '0; mIen = '0; mRun = 1'b0;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    checkAll("R1 reset");

    // R3: ticks while stopped change nothing
    doOp(0, 0, 0, 1);
    doOp(0, 0, 0, 1);
    rdChk("R3 sec stopped", 1);
    rdChk("R3 status stopped", 5);

    // R2: control, masking, stopwatch and unused index
    doOp(1, 4, 16'hFF7F, 0);
    rdChk("R2 ctrl run clear", 4);
    doOp(1, 4, 16'h0080, 0);
    rdChk("R2 ctrl run", 4);
    doOp(1, 0, 16'hFFFF, 0);
    rdChk("R2 hm masked", 0);
    doOp(1, 7, 16'hFFFF, 0);
    rdChk("R2 stopwatch zero", 7);
    rdChk("R2 unused index", 12);

    // R4: seconds step and wrap
    doOp(1, 0, hm(3, 10), 0);
    doOp(1, 1, 16'd58, 0);
    doOp(0, 0, 0, 1);
    rdChk("R4 sec step", 1);
    doOp(0, 0, 0, 1);
    rdChk("R4 sec wrap", 1);
    rdChk("R4 min carry", 0);

    // R5 and R6: full carry through the day wrap
    doOp(1, 8, 16'hFFFF, 0);
    doOp(1, 0, hm(23, 59), 0);
    doOp(1, 1, 16'd59, 0);
    doOp(0, 0, 0, 1);
    rdChk("R5 hm wrap", 0);
    rdChk("R6 day wrap", 8);
    rdChk("R4 sec zero", 1);

    // R7, R10: seconds event recorded while disabled
    doOp(1, 5, 16'hFFFF, 0);
    doOp(0, 0, 0, 1);
    rdChk("R7 sec event", 5);
    irqChk("R10 disabled no irq");
    doOp(1, 6, 16'hFFFF, 0);
    rdChk("R10 enable masked", 6);
    irqChk("R10 irq on enable");

    // R8: alarm across all four fields
    doOp(1, 5, 16'h0014, 0);
    doOp(1, 6, 16'h0004, 0);
    doOp(1, 8, 16'd5, 0);
    doOp(1, 0, hm(23, 59), 0);
    doOp(1, 1, 16'd58, 0);
    doOp(1, 9, 16'd6, 0);
    doOp(1, 2, hm(0, 0), 0);
    doOp(1, 3, 16'd0, 0);
    doOp(0, 0, 0, 1);
    rdChk("R8 no alarm yet", 5);
    irqChk("R8 no irq yet");
    doOp(0, 0, 0, 1);
    rdChk("R8 alarm event", 5);
    irqChk("R8 alarm irq");

    // R9: write one clears, zero keeps, set beats clear
    doOp(1, 5, 16'h0004, 0);
    rdChk("R9 clear alarm only", 5);
    irqChk("R9 irq drops");
    doOp(1, 5, 16'h0000, 0);
    rdChk("R9 zero keeps", 5);
    doOp(1, 5, 16'h0010, 1);
    rdChk("R9 set wins", 5);

    // R11: time write beats tick
    doOp(1, 1, 16'd10, 1);
    rdChk("R11 sec written", 1);
    rdChk("R11 hm held", 0);
    rdChk("R11 event kept", 5);
    doOp(1, 0, hm(4, 4), 1);
    rdChk("R11 sec held", 1);
    rdChk("R11 hm written", 0);

    checkAll("R2 directed sweep");

    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int sel = int'($urandom_range(0, 9));
      int idx = int'($urandom_range(0, 9));
      logic [15:0] d = 16'($urandom);
      bit tk = $urandom_range(0, 1) == 1;
      if (sel < 4) doOp(0, 0, 0, 1);
      else if (sel < 8) begin
        if (idx == 4) d[7] = ($urandom_range(0, 4) != 0);
        doOp(1, idx, d, tk);
      end else rdChk("R4 R5 R9 random read", idx);
      if (n % 50 == 0) checkAll("R10 random sweep");
    end
    checkAll("R11 final sweep");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule